// File: doc/BRIEF.md
# Debug Port Access Register for a JTAG Debug TAP

This block is the target-side logic behind the two access instructions of a JTAG debug TAP: one selects the debug-port registers, the other selects the access-port registers. While either instruction is active, a 35-bit data-register scan passes through the block. The first three bits shifted in form the request, and the last thirty-two bits form the data word. On the same scan the block shifts out a 3-bit acknowledge, followed by the result of the previous read. Reads are pipelined, so the data for a read appears in the scan that follows it.

Debug-port requests reach three registers inside the block. The control/status register holds the sticky flags, the overrun-detect enable and the power-up handshake. The bank-select register holds the access-port number and the register bank. A read-buffer address returns the last result again. Access-port requests are turned into a request/response handshake toward an access port. The access-port address is built from the selected bank and the two request address bits. At any time at most one access-port transaction is outstanding.

The control flow is a two-state machine for access-port transactions. `AP_IDLE` moves to `AP_BUSY` when an accepted access-port request is launched (transition *launch*). `AP_BUSY` returns to `AP_IDLE` when the access port signals completion (transition *complete*). While the machine is in `AP_BUSY`, the capture phase of a scan reports WAIT, unless overrun detection is enabled.

Top module: `dbg_acc_port`

## Requirements
- R1: Bits leave and enter the scan LSB first. Request bit 0 is RnW (1 = read), request bits [2:1] carry register address bits [3:2], and the next 32 bits are the data word. On `tdo` the acknowledge comes out first, then the 32-bit result.
- R2: The capture phase loads acknowledge 3'b010 (OK) when no access-port transaction is outstanding, and 3'b001 (WAIT) when one is outstanding and overrun detection is off. A request answered with WAIT has no effect.
- R3: A read result appears in the data field of the following scan. A debug-port read at address 0xC returns the held result and starts no access-port transaction. A debug-port read at address 0x0 returns zero. Writes to either of these two addresses change nothing.
- R4: The bank-select register (debug-port address 0x8) keeps bits [31:24] as the access-port number and bits [7:4] as the bank, and reads all other bits as zero. An access-port request drives `ap_sel` with the access-port number and `ap_addr` = {bank, A[3:2], 2'b00}.
- R5: An access-port request keeps `ap_req`, `ap_addr`, `ap_wr` and `ap_wdata` steady until `ap_done`. For a write, `ap_wr` is 1 and `ap_wdata` is the scanned data word.
- R6: An access-port response with `ap_err` set raises the sticky error flag, control/status bit 5. Writing 1 to bit 5 clears the flag.
- R7: Control/status bit 0 enables overrun detection. While it is set, a request that arrives during an outstanding transaction is acknowledged OK, is discarded, and raises the sticky overrun flag (bit 1). Writing 1 to bit 1 clears that flag.
- R8: While either sticky flag is set, access-port requests are acknowledged OK but start no transaction. Debug-port accesses still work.
- R9: Control/status bits 28 (debug domain) and 30 (system domain) are power-up requests. Their acknowledges, bits 29 and 31, follow each request after `PWR_DLY` cycles, both when the request rises and when it falls. With both domains powered, bits [31:28] read 4'hF.
- R10: After reset, control/status and bank-select are zero, the held result is zero, `ap_req` is low, and the first scan acknowledges OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_dp | input | 1 | Debug-port access instruction is active |
| sel_ap | input | 1 | Access-port access instruction is active |
| capture | input | 1 | Capture-DR cycle |
| shift | input | 1 | Shift-DR cycle |
| update | input | 1 | Update-DR cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req | output | 1 | Access-port transaction outstanding |
| ap_wr | output | 1 | Transaction is a write |
| ap_sel | output | 8 | Selected access-port number |
| ap_addr | output | 8 | Access-port register offset |
| ap_wdata | output | 32 | Write data |
| ap_done | input | 1 | Access port completes the transaction |
| ap_rdata | input | 32 | Read data from the access port |
| ap_err | input | 1 | Transaction ended with an error |

## Verification
The bench goes after the pipelining of reads. A design that returned data in the scan that issued the read, or that started a new transaction on a read-buffer access, would shift out the wrong words and change the transaction count. It holds a slow transaction open and scans again, once with overrun detection off and once with it on. A design that launched the second request, or reported WAIT when detection is on, is caught by the access-port model's record and by the sticky bits read back. It also checks that sticky flags block access-port traffic until they are cleared by writing 1, and that the power-up acknowledge bits follow their requests in both directions. A design that wired an acknowledge to the wrong request, or left a flag set after clearing, reads back a different control/status word.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;
    localparam int DW = 32;
    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    localparam int B_ORDET  = 0;
    localparam int B_STORUN = 1;
    localparam int B_STERR  = 5;
    localparam int B_DBGREQ = 28;
    localparam int B_DBGACK = 29;
    localparam int B_SYSREQ = 30;
    localparam int B_SYSACK = 31;

    typedef enum logic [1:0] {
        DP_RSVD  = 2'd0,
        DP_CTRL  = 2'd1,
        DP_SEL   = 2'd2,
        DP_RDBUF = 2'd3
    } dp_reg_e;

    typedef enum logic {
        AP_IDLE = 1'b0,
        AP_BUSY = 1'b1
    } ap_state_e;
endpackage

// File: rtl/dbgacc_shifter.sv
module dbgacc_shifter #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] word,
    output logic         tdo
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (capture) sr_q <= cap_word;
        else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
    end

    assign word = sr_q;
    assign tdo  = sr_q[0];
endmodule

// File: rtl/dbgacc_dpregs.sv
module dbgacc_dpregs
    import dbgacc_pkg::*;
#(
    parameter int PWR_DLY = 4,
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_sel,
    input  logic [DW-1:0] wdata,
    input  logic          set_orun,
    input  logic          set_err,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] sel_word,
    output logic          orun_det,
    output logic          sticky_any
);
    localparam int CW = $clog2(PWR_DLY + 1);
    localparam logic [DW-1:0] SEL_MASK =
        {{APSEL_W{1'b1}}, {(DW-APSEL_W-BANK_W-4){1'b0}}, {BANK_W{1'b1}}, 4'b0000};

    logic ordet_q, storun_q, sterr_q;
    logic [1:0] pwr_req, pwr_ack;
    logic [DW-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ordet_q  <= 1'b0;
            storun_q <= 1'b0;
            sterr_q  <= 1'b0;
            pwr_req  <= 2'b00;
            sel_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                ordet_q    <= wdata[B_ORDET];
                pwr_req[0] <= wdata[B_DBGREQ];
                pwr_req[1] <= wdata[B_SYSREQ];
            end
            storun_q <= (storun_q & ~(wr_ctrl & wdata[B_STORUN])) | set_orun;
            sterr_q  <= (sterr_q  & ~(wr_ctrl & wdata[B_STERR]))  | set_err;
            if (wr_sel) sel_q <= wdata & SEL_MASK;
        end
    end

    for (genvar d = 0; d < 2; d++) begin : g_pwr
        logic [CW-1:0] cnt_q;
        logic          ack_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                ack_q <= 1'b0;
            end else if (pwr_req[d] == ack_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(PWR_DLY - 1)) begin
                ack_q <= pwr_req[d];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign pwr_ack[d] = ack_q;

        assert_pwr_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ack_q) |-> $past(pwr_req[d]));
    end

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[B_ORDET]  = ordet_q;
        ctrl_word[B_STORUN] = storun_q;
        ctrl_word[B_STERR]  = sterr_q;
        ctrl_word[B_DBGREQ] = pwr_req[0];
        ctrl_word[B_DBGACK] = pwr_ack[0];
        ctrl_word[B_SYSREQ] = pwr_req[1];
        ctrl_word[B_SYSACK] = pwr_ack[1];
    end

    assign sel_word   = sel_q;
    assign orun_det   = ordet_q;
    assign sticky_any = storun_q | sterr_q;

    assert_orun_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (storun_q && !(wr_ctrl && wdata[B_STORUN])) |=> storun_q);
    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sterr_q && !(wr_ctrl && wdata[B_STERR])) |=> sterr_q);
endmodule

// File: rtl/dbgacc_apfsm.sv
module dbgacc_apfsm
    import dbgacc_pkg::*;
#(
    parameter int APSEL_W = 8,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [APSEL_W-1:0] apsel,
    input  logic [DW-1:0]      wdata,
    input  logic               ap_done,
    input  logic [DW-1:0]      ap_rdata,
    input  logic               ap_err,
    output logic               busy,
    output logic               ap_req,
    output logic               ap_wr,
    output logic [ADDR_W-1:0]  ap_addr,
    output logic [APSEL_W-1:0] ap_sel,
    output logic [DW-1:0]      ap_wdata,
    output logic               resp_valid,
    output logic               resp_rd,
    output logic [DW-1:0]      resp_data,
    output logic               resp_err
);
    ap_state_e st_q, st_nx;
    logic               wr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [APSEL_W-1:0] sel_q;
    logic [DW-1:0]      wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AP_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            AP_IDLE: if (launch)  st_nx = AP_BUSY;
            AP_BUSY: if (ap_done) st_nx = AP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
        end else if (launch && st_q == AP_IDLE) begin
            wr_q    <= wr;
            addr_q  <= addr;
            sel_q   <= apsel;
            wdata_q <= wdata;
        end
    end

    always_comb begin
        busy       = (st_q == AP_BUSY);
        ap_req     = (st_q == AP_BUSY);
        resp_valid = (st_q == AP_BUSY) && ap_done;
        ap_wr      = wr_q;
        ap_addr    = addr_q;
        ap_sel     = sel_q;
        ap_wdata   = wdata_q;
        resp_rd    = !wr_q;
        resp_data  = ap_rdata;
        resp_err   = ap_err;
    end

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && !ap_done) |=> (ap_req && $stable(ap_addr) && $stable(ap_wdata) && $stable(ap_wr)));
endmodule

// File: rtl/dbg_acc_port.sv
module dbg_acc_port
    import dbgacc_pkg::*;
#(
    parameter int PWR_DLY = 4,
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_dp,
    input  logic               sel_ap,
    input  logic               capture,
    input  logic               shift,
    input  logic               update,
    input  logic               tdi,
    output logic               tdo,
    output logic               ap_req,
    output logic               ap_wr,
    output logic [APSEL_W-1:0] ap_sel,
    output logic [BANK_W+3:0]  ap_addr,
    output logic [DW-1:0]      ap_wdata,
    input  logic               ap_done,
    input  logic [DW-1:0]      ap_rdata,
    input  logic               ap_err
);
    localparam int SW     = DW + 3;
    localparam int ADDR_W = BANK_W + 4;

    logic cap_en, sh_en, upd_dp, upd_ap;
    logic [SW-1:0] scan_word, cap_word;
    logic [2:0]    ack_now;
    logic [1:0]    req_a;
    logic          req_rnw;
    logic [DW-1:0] req_data, rd_q, rd_next, ctrl_word, sel_word;
    logic          rd_load, busy_cap_q, busy, orun_det, sticky_any;
    logic          wr_ctrl, wr_sel, set_orun, launch;
    logic          resp_valid, resp_rd, resp_err;
    logic [DW-1:0] resp_data;

    assign cap_en   = capture & (sel_dp | sel_ap);
    assign sh_en    = shift & (sel_dp | sel_ap);
    assign upd_dp   = update & sel_dp;
    assign upd_ap   = update & sel_ap & ~sel_dp;
    assign ack_now  = (busy && !orun_det) ? ACK_WAIT : ACK_OK;
    assign cap_word = {rd_q, ack_now};
    assign req_rnw  = scan_word[0];
    assign req_a    = scan_word[2:1];
    assign req_data = scan_word[SW-1:3];

    dbgacc_shifter #(.W(SW)) u_shift (
        .clk(clk), .rst_n(rst_n), .capture(cap_en), .shift(sh_en), .tdi(tdi),
        .cap_word(cap_word), .word(scan_word), .tdo(tdo)
    );

    dbgacc_dpregs #(.PWR_DLY(PWR_DLY), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_sel(wr_sel), .wdata(req_data),
        .set_orun(set_orun), .set_err(resp_valid & resp_err),
        .ctrl_word(ctrl_word), .sel_word(sel_word), .orun_det(orun_det), .sticky_any(sticky_any)
    );

    dbgacc_apfsm #(.APSEL_W(APSEL_W), .ADDR_W(ADDR_W)) u_ap (
        .clk(clk), .rst_n(rst_n), .launch(launch), .wr(~req_rnw),
        .addr({sel_word[4 +: BANK_W], req_a, 2'b00}),
        .apsel(sel_word[DW-1 -: APSEL_W]), .wdata(req_data),
        .ap_done(ap_done), .ap_rdata(ap_rdata), .ap_err(ap_err),
        .busy(busy), .ap_req(ap_req), .ap_wr(ap_wr), .ap_addr(ap_addr), .ap_sel(ap_sel),
        .ap_wdata(ap_wdata), .resp_valid(resp_valid), .resp_rd(resp_rd),
        .resp_data(resp_data), .resp_err(resp_err)
    );

    always_comb begin
        wr_ctrl  = 1'b0;
        wr_sel   = 1'b0;
        set_orun = 1'b0;
        launch   = 1'b0;
        rd_load  = 1'b0;
        rd_next  = rd_q;
        if (upd_dp || upd_ap) begin
            if (busy_cap_q) begin
                set_orun = orun_det;
            end else if (upd_dp) begin
                if (req_rnw) begin
                    rd_load = 1'b1;
                    unique case (dp_reg_e'(req_a))
                        DP_CTRL:  rd_next = ctrl_word;
                        DP_SEL:   rd_next = sel_word;
                        DP_RDBUF: rd_next = rd_q;
                        default:  rd_next = '0;
                    endcase
                end else begin
                    wr_ctrl = (req_a == DP_CTRL);
                    wr_sel  = (req_a == DP_SEL);
                end
            end else if (!sticky_any) begin
                launch = 1'b1;
            end
        end
        if (resp_valid && resp_rd) begin
            rd_load = 1'b1;
            rd_next = resp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q       <= '0;
            busy_cap_q <= 1'b0;
        end else begin
            if (rd_load) rd_q <= rd_next;
            if (cap_en)  busy_cap_q <= busy;
        end
    end

    assert_ack_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (scan_word[2:0] == ACK_OK || scan_word[2:0] == ACK_WAIT));
    assert_wait_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((upd_dp || upd_ap) && busy_cap_q && !ap_req) |=> !ap_req);
    assert_sticky_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ap && !busy_cap_q && sticky_any && !ap_req) |=> !ap_req);
endmodule

// File: tb/tb_dbg_acc_port.sv
`timescale 1ns/1ps
module tb_dbg_acc_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_dp = 0, sel_ap = 0, capture = 0, shift = 0, update = 0, tdi = 0;
    logic tdo, ap_req, ap_wr;
    logic [7:0] ap_sel, ap_addr;
    logic [31:0] ap_wdata;
    logic ap_done = 0, ap_err = 0;
    logic [31:0] ap_rdata = '0;

    int total = 0, bad = 0;
    int ap_lat = 2, ap_cnt = 0, lat_cnt = 0;
    bit err_next = 0;
    logic [7:0] last_addr = '0, last_sel = '0;
    logic last_wr = 0;
    logic [31:0] last_wdata = '0;

    logic [98:0] exp_q[$];
    string tag_q[$];
    logic [34:0] got;
    event scan_done;

    always #2.5 clk = ~clk;

    dbg_acc_port dut (
        .clk(clk), .rst_n(rst_n), .sel_dp(sel_dp), .sel_ap(sel_ap), .capture(capture),
        .shift(shift), .update(update), .tdi(tdi), .tdo(tdo), .ap_req(ap_req), .ap_wr(ap_wr),
        .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_done(ap_done),
        .ap_rdata(ap_rdata), .ap_err(ap_err)
    );

    // access-port model: completes ap_lat cycles after a request appears
    always @(negedge clk) begin
        if (ap_done) begin
            ap_done = 0; ap_err = 0; lat_cnt = 0;
        end else if (ap_req) begin
            lat_cnt++;
            if (lat_cnt >= ap_lat) begin
                ap_done = 1; ap_err = err_next;
                ap_rdata = 32'hC0DE_0000 | {24'h0, ap_addr};
                last_addr = ap_addr; last_sel = ap_sel; last_wr = ap_wr; last_wdata = ap_wdata;
                ap_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected scan results and compares with what came out of tdo
    initial begin
        forever begin
            @(scan_done);
            begin
                logic [98:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got[2:0] == e[98:96], {t, " ack"}, {29'b0, got[2:0]}, {29'b0, e[98:96]});
                chk((got[34:3] & e[31:0]) == (e[95:64] & e[31:0]), {t, " data"}, got[34:3], e[95:64]);
            end
        end
    end

    task automatic scan(input bit ap, input logic [3:0] a, input bit rnw, input logic [31:0] wd,
                        input logic [2:0] eack, input logic [31:0] edata, input string tag);
        logic [34:0] tx, rx;
        tx = {wd, a[3:2], rnw};
        exp_q.push_back({eack, edata, 32'h0, 32'hFFFF_FFFF});
        tag_q.push_back(tag);
        @(negedge clk); sel_dp = !ap; sel_ap = ap; capture = 1;
        @(negedge clk); capture = 0;
        for (int i = 0; i < 35; i++) begin
            shift = 1; tdi = tx[i]; rx[i] = tdo;
            @(negedge clk);
        end
        shift = 0; update = 1;
        @(negedge clk); update = 0; sel_dp = 0; sel_ap = 0;
        repeat (12) @(negedge clk);
        got = rx;
        -> scan_done;
    endtask

    localparam logic [2:0] OK = 3'b010, WT = 3'b001;

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ap_req == 0, "R10 ap_req after reset", {31'b0, ap_req}, 0);
        // R10 reset state
        scan(0, 4'hC, 1, 0, OK, 32'h0, "R10 first scan");
        scan(0, 4'h4, 1, 0, OK, 32'h0, "R10 rdbuf zero");
        scan(0, 4'h8, 1, 0, OK, 32'h0, "R10 ctrl zero");
        // R4 select, R1 field order
        scan(0, 4'h8, 0, 32'hAB00_00F5, OK, 32'h0, "R10 select zero");
        scan(0, 4'h8, 1, 0, OK, 32'h0, "R1 write leaves result");
        scan(0, 4'hC, 1, 0, OK, 32'hAB00_00F0, "R4 select masked");
        scan(0, 4'hC, 1, 0, OK, 32'hAB00_00F0, "R3 rdbuf holds");
        // R4 banked AP address
        scan(1, 4'h4, 1, 0, OK, 32'hAB00_00F0, "R3 ap read returns old");
        chk(last_addr == 8'hF4, "R4 ap_addr", {24'b0, last_addr}, 32'hF4);
        chk(last_sel == 8'hAB, "R4 ap_sel", {24'b0, last_sel}, 32'hAB);
        chk(ap_cnt == 1, "R4 one transaction", ap_cnt, 1);
        scan(0, 4'hC, 1, 0, OK, 32'hC0DE_00F4, "R3 next scan data");
        chk(ap_cnt == 1, "R3 rdbuf no ap access", ap_cnt, 1);
        // R3 pipelined reads
        scan(0, 4'h8, 0, 32'h0, OK, 32'hC0DE_00F4, "R4 select clear");
        scan(1, 4'h8, 1, 0, OK, 32'hC0DE_00F4, "R3 pipe read 1");
        scan(1, 4'hC, 1, 0, OK, 32'hC0DE_0008, "R3 pipe read 2");
        scan(0, 4'hC, 1, 0, OK, 32'hC0DE_000C, "R3 pipe drain");
        scan(0, 4'h0, 0, 32'hFFFF_FFFF, OK, 32'hC0DE_000C, "R3 rsvd write");
        scan(0, 4'h0, 1, 0, OK, 32'hC0DE_000C, "R3 rsvd write no effect");
        scan(0, 4'hC, 0, 32'h1111_1111, OK, 32'h0, "R3 rsvd reads zero");
        scan(0, 4'hC, 1, 0, OK, 32'h0, "R3 rdbuf write ignored");
        // R5 AP write
        scan(1, 4'h0, 0, 32'h1234_5678, OK, 32'h0, "R5 ap write");
        chk(last_wr == 1 && last_wdata == 32'h1234_5678 && last_addr == 8'h00, "R5 write fields",
            last_wdata, 32'h1234_5678);
        // R2 WAIT while busy
        base = ap_cnt;
        ap_lat = 60;
        scan(1, 4'h4, 1, 0, OK, 32'h0, "R2 slow read");
        scan(1, 4'h8, 0, 32'hDEAD, WT, 32'h0, "R2 wait ack");
        repeat (80) @(negedge clk);
        chk(ap_cnt == base + 1 && last_wr == 0 && last_addr == 8'h04, "R2 waited request ignored",
            ap_cnt, base + 1);
        ap_lat = 2;
        scan(0, 4'hC, 1, 0, OK, 32'hC0DE_0004, "R2 slow read result");
        // R7 overrun detect
        scan(0, 4'h4, 0, 32'h1, OK, 32'hC0DE_0004, "R7 enable detect");
        base = ap_cnt;
        ap_lat = 60;
        scan(1, 4'h0, 1, 0, OK, 32'hC0DE_0004, "R7 slow read");
        scan(1, 4'h4, 0, 32'h99, OK, 32'hC0DE_0004, "R7 overrun ack ok");
        repeat (80) @(negedge clk);
        ap_lat = 2;
        chk(ap_cnt == base + 1, "R7 overrun request dropped", ap_cnt, base + 1);
        scan(0, 4'h4, 1, 0, OK, 32'hC0DE_0000, "R7 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h0000_0003, "R7 sticky overrun set");
        // R8 sticky blocks AP
        base = ap_cnt;
        scan(1, 4'h4, 0, 32'h55, OK, 32'h3, "R8 ack ok when sticky");
        chk(ap_cnt == base, "R8 ap request discarded", ap_cnt, base);
        scan(0, 4'h4, 0, 32'h3, OK, 32'h3, "R7 clear overrun");
        scan(0, 4'h4, 1, 0, OK, 32'h3, "R7 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h1, "R7 overrun cleared");
        scan(1, 4'h4, 0, 32'h55, OK, 32'h1, "R8 ap resumes");
        chk(ap_cnt == base + 1 && last_wdata == 32'h55, "R8 ap resumes count", ap_cnt, base + 1);
        // R6 sticky error
        err_next = 1;
        scan(1, 4'h8, 0, 32'h77, OK, 32'h1, "R6 erroring write");
        err_next = 0;
        scan(0, 4'h4, 1, 0, OK, 32'h1, "R6 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h21, "R6 sticky error set");
        base = ap_cnt;
        scan(1, 4'h0, 0, 32'h66, OK, 32'h21, "R8 error blocks ap");
        chk(ap_cnt == base, "R8 error discards ap", ap_cnt, base);
        scan(0, 4'h4, 0, 32'h20, OK, 32'h21, "R6 clear error");
        scan(0, 4'h4, 1, 0, OK, 32'h21, "R6 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h0, "R6 error cleared");
        // R9 power handshake
        scan(0, 4'h4, 0, 32'h5000_0000, OK, 32'h0, "R9 request both");
        scan(0, 4'h4, 1, 0, OK, 32'h0, "R9 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'hF000_0000, "R9 both powered");
        scan(0, 4'h4, 0, 32'h1000_0000, OK, 32'hF000_0000, "R9 drop system");
        scan(0, 4'h4, 1, 0, OK, 32'hF000_0000, "R9 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h3000_0000, "R9 debug only");
        scan(0, 4'h4, 0, 32'h0, OK, 32'h3000_0000, "R9 drop all");
        scan(0, 4'h4, 1, 0, OK, 32'h3000_0000, "R9 read ctrl");
        scan(0, 4'hC, 1, 0, OK, 32'h0, "R9 all off");
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule